// File: doc/BRIEF.md
# Elapsed-Cycle Meter with Hex Readout

This block measures how many clock cycles a piece of work takes, for example a sort run by a soft processor or by dedicated hardware. Software writes a small command word to start the count from zero, to halt it, and to switch its readout on or off. The count is a wide free-running register that advances by one on every clock edge while the meter is running. When the count passes its all-ones value it rolls over to zero and raises no flag.

The readout is a bank of hexadecimal seven-segment digits. A select input picks either the lowest slice of the count or the slice just above it. While a measurement is in progress and the readout is on, every digit shows a single middle bar. When the readout is off, all segments are dark. The digits are driven in parallel. Any time-multiplexing of the digits is left to the pad logic that follows.

Top module: `cycle_meter`

## Requirements
- R1: After `rst_n` is asserted low, the count is zero, the meter is halted and every segment output is 0.
- R2: A command write with bit 0 set clears the count to zero and starts the meter. From the next clock edge on, the count rises by one per edge, so a halt written N edges after the start leaves the count at N.
- R3: A command write with bit 1 set and bit 0 clear halts the meter. The count then holds its value across any number of later clocks.
- R4: When bits 0 and 1 are written together, the start wins. The count restarts from zero and the meter runs.
- R5: Every command write copies bit 2 into the readout enable. While it is 0, every segment output is 0.
- R6: While the meter runs and the readout is enabled, every digit shows the bar code 7'h40 (only segment g lit).
- R7: While the meter is halted and the readout is enabled, each digit shows one nibble of the selected slice in hex. Digit 0 occupies `seg_out[6:0]` and shows the least significant nibble. Segment bits are {g,f,e,d,c,b,a}, active high. The codes for values 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R8: With `view_hi` at 0, the readout shows count bits SLICE_W-1..0. With `view_hi` at 1, it shows bits 2*SLICE_W-1..SLICE_W. A change of `view_hi` shows without a clock edge.
- R9: After the all-ones value, the count wraps to zero and keeps counting.
- R10: A command write with bits 0 and 1 both clear leaves the count and the run state untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | CMD_W | Command word: bit 0 start, bit 1 halt, bit 2 readout enable |
| view_hi | input | 1 | Selects the upper (1) or lower (0) slice for the readout |
| seg_out | output | 7*SLICE_W/4 | Segment codes, seven bits per digit, digit 0 lowest |

## Verification
The count register is only visible through the readout. Once the meter halts, a wrong count therefore shows as a wrong hex digit right away, in either slice. A run-state register stuck high or low shows at once as bars where digits belong, or the reverse. An off-by-one at the start or halt edge shows in every measurement of the length sweep. A fault in the carry between adder segments only shows when a lower segment rolls over. The sweep and the wrap run are long enough to make that happen.

// File: rtl/cyc_meter_pkg.sv
package cyc_meter_pkg;

   // command word bit positions
   localparam int unsigned CMD_START_BIT = 0;
   localparam int unsigned CMD_HALT_BIT  = 1;
   localparam int unsigned CMD_SHOW_BIT  = 2;

   // segment codes, bit order {g,f,e,d,c,b,a}, active high
   localparam logic [6:0] SEG_BAR = 7'h40;
   localparam logic [6:0] SEG_OFF = 7'h00;

   function automatic logic [6:0] nibble_to_seg(input logic [3:0] v);
      logic [6:0] s;
      case (v)
         4'h0: s = 7'h3F;
         4'h1: s = 7'h06;
         4'h2: s = 7'h5B;
         4'h3: s = 7'h4F;
         4'h4: s = 7'h66;
         4'h5: s = 7'h6D;
         4'h6: s = 7'h7D;
         4'h7: s = 7'h07;
         4'h8: s = 7'h7F;
         4'h9: s = 7'h6F;
         4'hA: s = 7'h77;
         4'hB: s = 7'h7C;
         4'hC: s = 7'h39;
         4'hD: s = 7'h5E;
         4'hE: s = 7'h79;
         default: s = 7'h71;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/cyc_cmd_ctrl.sv
module cyc_cmd_ctrl
   import cyc_meter_pkg::*;
#(
   parameter int unsigned CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [CMD_W-1:0] cmd_data,
   output logic             start_req,
   output logic             running,
   output logic             show
);

   logic halt_req;

   assign start_req = cmd_we & cmd_data[CMD_START_BIT];
   assign halt_req  = cmd_we & cmd_data[CMD_HALT_BIT];

   generate
      if (CMD_W > 3) begin : g_spare
         logic unused_cmd_bits;
         assign unused_cmd_bits = ^cmd_data[CMD_W-1:3];
      end
   endgenerate

   // start has priority over halt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
      end else if (start_req) begin
         running <= 1'b1;
      end else if (halt_req) begin
         running <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         show <= 1'b0;
      end else if (cmd_we) begin
         show <= cmd_data[CMD_SHOW_BIT];
      end
   end

   // R4
   start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_data[CMD_START_BIT] && cmd_data[CMD_HALT_BIT]) |=> running);

   // R3
   halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_data[CMD_HALT_BIT] && !cmd_data[CMD_START_BIT]) |=> !running);

   // R10
   idle_write_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_data[CMD_HALT_BIT] && !cmd_data[CMD_START_BIT])
      |=> (running == $past(running)));

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned SEG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] count_inc;

   generate
      if (CNT_W > SEG_W) begin : g_split
         // segmented increment: upper part adds the lower part's carry
         localparam int unsigned HI_W = CNT_W - SEG_W;
         logic [SEG_W-1:0] lo_q;
         logic [HI_W-1:0]  hi_q;
         logic             lo_full;
         assign lo_q    = count[SEG_W-1:0];
         assign hi_q    = count[CNT_W-1:SEG_W];
         assign lo_full = &lo_q;
         assign count_inc = {hi_q + HI_W'(lo_full), lo_q + SEG_W'(1)};
      end else begin : g_flat
         assign count_inc = count + CNT_W'(1);
      end
   endgenerate

   // wraps silently after all ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (run) begin
         count <= count_inc;
      end
   end

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

   // R2, R9
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear) |=> (count == $past(count) + CNT_W'(1)));

   // R3
   hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(count));

endmodule

// File: rtl/cyc_seg_stage.sv
module cyc_seg_stage
   import cyc_meter_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned SLICE_W = 16,
   localparam int unsigned DIGITS = SLICE_W / 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CNT_W-1:0]    count,
   input  logic                view_hi,
   input  logic                running,
   input  logic                show,
   output logic [DIGITS*7-1:0] seg_out
);

   logic [SLICE_W-1:0] slice;

   assign slice = view_hi ? count[2*SLICE_W-1:SLICE_W] : count[SLICE_W-1:0];

   generate
      if (CNT_W > 2*SLICE_W) begin : g_spare
         logic unused_high_count;
         assign unused_high_count = ^count[CNT_W-1:2*SLICE_W];
      end

      for (genvar d = 0; d < DIGITS; d++) begin : g_digit
         logic [6:0] code;
         always_comb begin
            if (!show) begin
               code = SEG_OFF;
            end else if (running) begin
               code = SEG_BAR;
            end else begin
               code = nibble_to_seg(slice[d*4 +: 4]);
            end
         end
         assign seg_out[d*7 +: 7] = code;

         // R6
         bar_while_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (show && running) |-> (seg_out[d*7 +: 7] == SEG_BAR));

         // R7
         halted_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (show && !running) |-> (seg_out[d*7 +: 7] != SEG_OFF));
      end
   endgenerate

   // R5
   dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !show |-> (seg_out == '0));

endmodule

// File: rtl/cycle_meter.sv
module cycle_meter
   import cyc_meter_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned SLICE_W = 16,
   parameter int unsigned CMD_W   = 8,
   parameter int unsigned SEG_W   = 32,
   localparam int unsigned DIGITS = SLICE_W / 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_we,
   input  logic [CMD_W-1:0]    cmd_data,
   input  logic                view_hi,
   output logic [DIGITS*7-1:0] seg_out
);

   generate
      if (CMD_W < 3) begin : g_bad_cmd
         $error("cycle_meter: CMD_W must hold three command bits");
      end
      if ((SLICE_W % 4) != 0 || SLICE_W == 0) begin : g_bad_slice
         $error("cycle_meter: SLICE_W must be a non-zero multiple of 4");
      end
      if (CNT_W < 2*SLICE_W) begin : g_bad_cnt
         $error("cycle_meter: CNT_W must cover two readout slices");
      end
      if (SEG_W == 0) begin : g_bad_seg
         $error("cycle_meter: SEG_W must be non-zero");
      end
   endgenerate

   logic             start_req;
   logic             running;
   logic             show;
   logic [CNT_W-1:0] count;

   cyc_cmd_ctrl #(
      .CMD_W (CMD_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (cmd_we),
      .cmd_data  (cmd_data),
      .start_req (start_req),
      .running   (running),
      .show      (show)
   );

   cyc_count_core #(
      .CNT_W (CNT_W),
      .SEG_W (SEG_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_req),
      .run   (running),
      .count (count)
   );

   cyc_seg_stage #(
      .CNT_W   (CNT_W),
      .SLICE_W (SLICE_W)
   ) u_seg (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count),
      .view_hi (view_hi),
      .running (running),
      .show    (show),
      .seg_out (seg_out)
   );

   // R1
   reset_dark_chk: assert property (@(posedge clk)
      !rst_n |-> (seg_out == '0));

endmodule

// File: tb/cycle_meter_test.sv
`timescale 1ns/1ps
module cycle_meter_test;

   localparam int unsigned CNT_W   = 16;
   localparam int unsigned SLICE_W = 8;
   localparam int unsigned CMD_W   = 8;
   localparam int unsigned SEG_W   = 8;
   localparam int unsigned SEGS    = (SLICE_W / 4) * 7;
   localparam logic [SEGS-1:0] ALL_BAR = {2{7'h40}};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_we = 1'b0;
   logic [CMD_W-1:0] cmd_data = '0;
   logic            view_hi = 1'b0;
   logic [SEGS-1:0] seg_out;

   int tests_run = 0;
   int tests_failed = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cycle_meter #(
      .CNT_W (CNT_W), .SLICE_W (SLICE_W), .CMD_W (CMD_W), .SEG_W (SEG_W)
   ) uut (
      .clk (clk), .rst_n (rst_n), .cmd_we (cmd_we), .cmd_data (cmd_data),
      .view_hi (view_hi), .seg_out (seg_out)
   );

   function automatic logic [6:0] want_seg(input logic [3:0] v);
      logic [6:0] s;
      case (v)
         4'h0: s = 7'h3F; 4'h1: s = 7'h06; 4'h2: s = 7'h5B; 4'h3: s = 7'h4F;
         4'h4: s = 7'h66; 4'h5: s = 7'h6D; 4'h6: s = 7'h7D; 4'h7: s = 7'h07;
         4'h8: s = 7'h7F; 4'h9: s = 7'h6F; 4'hA: s = 7'h77; 4'hB: s = 7'h7C;
         4'hC: s = 7'h39; 4'hD: s = 7'h5E; 4'hE: s = 7'h79; default: s = 7'h71;
      endcase
      return s;
   endfunction

   function automatic logic [SEGS-1:0] want_view(input int cnt, input bit hi);
      logic [15:0] c;
      logic [7:0]  sl;
      c  = 16'(cnt);
      sl = hi ? c[15:8] : c[7:0];
      return {want_seg(sl[7:4]), want_seg(sl[3:0])};
   endfunction

   task automatic check(input string req, input logic [SEGS-1:0] got,
                        input logic [SEGS-1:0] exp);
      tests_run++;
      if (got !== exp) begin
         tests_failed++;
         $display("FAIL %s: seg_out=%h expected %h", req, got, exp);
      end
   endtask

   // start at one edge, halt n edges later; sample at the negedge after halt
   task automatic measure(input int n, input logic [7:0] start_cmd,
                          input logic [7:0] halt_cmd);
      @(negedge clk);
      cmd_we = 1'b1; cmd_data = start_cmd;
      @(negedge clk);
      cmd_we = 1'b0;
      repeat (n - 1) @(negedge clk);
      cmd_we = 1'b1; cmd_data = halt_cmd;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic write_cmd(input logic [7:0] c);
      @(negedge clk);
      cmd_we = 1'b1; cmd_data = c;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic check_both(input string req, input int cnt);
      view_hi = 1'b0; #1;
      check(req, seg_out, want_view(cnt, 1'b0));
      view_hi = 1'b1; #1;
      check(req, seg_out, want_view(cnt, 1'b1));
      view_hi = 1'b0; #1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state is dark
      check("R1", seg_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", seg_out, '0);
      // R5: enabling readout without a start shows a zero count
      write_cmd(8'h04);
      check_both("R1", 0);

      // R2, R7, R8: sweep run lengths, both slices
      for (int n = 1; n <= 300; n++) begin
         measure(n, 8'h05, 8'h06);
         check_both("R2/R7/R8", n);
      end

      // R3: frozen after halt across many clocks
      repeat (50) @(negedge clk);
      check_both("R3", 300);

      // R6: bars while running
      @(negedge clk);
      cmd_we = 1'b1; cmd_data = 8'h05;
      @(negedge clk);
      cmd_we = 1'b0;
      check("R6", seg_out, ALL_BAR);
      view_hi = 1'b1; #1;
      check("R6", seg_out, ALL_BAR);
      view_hi = 1'b0;
      write_cmd(8'h06);

      // R4: start and halt together -> start wins
      measure(7, 8'h07, 8'h06);
      check_both("R4", 7);
      @(negedge clk);
      cmd_we = 1'b1; cmd_data = 8'h07;
      @(negedge clk);
      cmd_we = 1'b0;
      check("R4", seg_out, ALL_BAR);
      write_cmd(8'h06);

      // R10: display-only write mid-run does not disturb the count
      @(negedge clk);
      cmd_we = 1'b1; cmd_data = 8'h05;
      @(negedge clk);
      cmd_we = 1'b0;
      repeat (9) @(negedge clk);
      cmd_we = 1'b1; cmd_data = 8'h04;   // edge start+10
      @(negedge clk);
      cmd_we = 1'b0;
      check("R10", seg_out, ALL_BAR);
      repeat (9) @(negedge clk);
      cmd_we = 1'b1; cmd_data = 8'h06;   // edge start+20
      @(negedge clk);
      cmd_we = 1'b0;
      check_both("R10", 20);

      // R5: readout off goes dark, count kept; back on shows it
      write_cmd(8'h00);
      check("R5", seg_out, '0);
      view_hi = 1'b1; #1;
      check("R5", seg_out, '0);
      view_hi = 1'b0;
      repeat (5) @(negedge clk);
      write_cmd(8'h04);
      check_both("R10", 20);

      // R5: running with readout off stays dark, then shows on halt
      @(negedge clk);
      cmd_we = 1'b1; cmd_data = 8'h01;
      @(negedge clk);
      cmd_we = 1'b0;
      check("R5", seg_out, '0);
      repeat (12) @(negedge clk);
      cmd_we = 1'b1; cmd_data = 8'h06;   // edge start+13
      @(negedge clk);
      cmd_we = 1'b0;
      check_both("R5", 13);

      // R9: wrap past all ones
      measure(65536 + 5, 8'h05, 8'h06);
      check_both("R9", 5);
      measure(65535, 8'h05, 8'h06);
      check_both("R9", 65535);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule